// File: doc/BRIEF.md
# Paged Serial-Memory Storage Controller

This block sits behind the bit-level engine of a two-wire serial memory slave and owns the storage. It keeps a byte array with a word-address pointer. It collects the data bytes of one write sequence in a page-sized staging buffer. It commits the buffer to the array in a single timed write cycle, which starts when the sequence ends with a stop. The protocol engine talks to it through one-cycle strobes: load a word address, push a data byte, pull a data byte, and report a stop.

Writes and reads move the pointer differently. A pushed byte advances only the in-page part of the pointer, so a long write circles back over the start of the same page. A pulled byte advances the whole pointer, so a long read runs on across pages and from the top of the array back to address 0. A protect input guards the upper half of the array. Bytes aimed at the upper half are still accepted and still advance the pointer, but the commit drops them.

While the write cycle runs, a busy output is high and every strobe is ignored. The protocol engine uses busy to withhold its acknowledge.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset, busy is 0, read data is 0x00, the pointer is 0 and every array byte reads 0x00.
- R2: A load strobe sets the pointer to addr_i. A read strobe places the byte at the pointer on rdata_o in the next cycle and increments the pointer. When strobes coincide, load wins over push, push over pull, and pull over stop.
- R3: A read at address 511 returns that byte and moves the pointer to 0.
- R4: Each pushed byte is staged for the pointer's byte-in-page slot (pointer bits 3:0). Only those 4 bits increment; pointer bits 8:4 never change during a write.
- R5: When more than 16 bytes are pushed in one sequence, the later bytes replace the earlier ones in the same slots. Bytes of the page that were not pushed keep their old contents.
- R6: A stop after at least one pushed byte holds busy high for exactly WR_CYCLES clock cycles, starting in the cycle after the stop. The staged bytes appear in the array when busy falls.
- R7: A stop with no pushed byte since the last load (a dummy write) leaves busy low, and the pointer keeps the loaded address.
- R8: While busy is high, load, push, pull and stop strobes have no effect on the pointer, the array or rdata_o. This includes a pull in the last busy cycle.
- R9: If prot_i is 1 at the stop, bytes staged for addresses 256..511 are dropped and bytes for 0..255 are written. If prot_i is 0, all staged bytes are written.
- R10: After a write, the pointer holds the last pushed slot plus one, wrapped inside the page. A following read with no load returns the byte at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prot_i | input | 1 | Protect upper half of the array |
| load_i | input | 1 | Load-address strobe |
| addr_i | input | ADDR_W | Word address for load |
| wr_i | input | 1 | Push-byte strobe |
| wdata_i | input | DATA_W | Byte to push |
| rd_i | input | 1 | Pull-byte strobe |
| stop_i | input | 1 | Stop-seen strobe |
| rdata_o | output | DATA_W | Last pulled byte |
| busy_o | output | 1 | Write cycle in progress |

## Verification
The end of a write cycle and a new strobe can fall in the same cycle: the array commits on the same edge where a pull strobe would otherwise be taken. The bench provokes this by counting busy cycles after a stop and pulsing a pull in exactly the last one. It then judges the result three ways. rdata_o must be unchanged. A current-address read must show that the pointer did not move. A reload and read must return the freshly committed bytes.

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int CNT_W    = $clog2(WR_CYCLES + 1);

  logic [DATA_W-1:0]   mem  [DEPTH];
  logic [DATA_W-1:0]   pbuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pvalid;
  logic [ADDR_W-1:0]   ptr;
  logic [CNT_W-1:0]    tmr;
  logic                cprot;

  wire idle    = (tmr == '0);
  wire do_ld   = idle & load_i;
  wire do_wr   = idle & ~load_i & wr_i;
  wire do_rd   = idle & ~load_i & ~wr_i & rd_i;
  wire do_stop = idle & ~load_i & ~wr_i & ~rd_i & stop_i;
  wire commit  = (tmr == CNT_W'(1));
  wire drop    = cprot & ptr[ADDR_W-1];

  assign busy_o = ~idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      ptr     <= '0;
      pvalid  <= '0;
      cprot   <= 1'b0;
      rdata_o <= '0;
      for (int i = 0; i < PAGE_LEN; i++) pbuf[i] <= '0;
    end else begin
      if (do_stop && pvalid != '0) begin
        tmr   <= CNT_W'(WR_CYCLES);
        cprot <= prot_i;
      end else if (!idle) begin
        tmr <= tmr - CNT_W'(1);
      end
      if (do_ld || commit) pvalid <= '0;
      else if (do_wr) pvalid[ptr[PAGE_W-1:0]] <= 1'b1;
      if (do_wr) pbuf[ptr[PAGE_W-1:0]] <= wdata_i;
      if (do_ld)
        ptr <= addr_i;
      else if (do_wr)
        ptr <= {ptr[ADDR_W-1:PAGE_W], PAGE_W'(ptr[PAGE_W-1:0] + 1'b1)};
      else if (do_rd)
        ptr <= ptr + 1'b1;
      if (do_rd) rdata_o <= mem[ptr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit && !drop) begin
      for (int j = 0; j < PAGE_LEN; j++)
        if (pvalid[j]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(j)}] <= pbuf[j];
    end
  end
endmodule

module eeprom_page_ctrl_chk #(
  parameter int ADDR_W    = 9,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      load_i,
  input logic                      wr_i,
  input logic                      rd_i,
  input logic                      stop_i,
  input logic [DATA_W-1:0]         rdata_o,
  input logic                      busy_o,
  input logic [ADDR_W-1:0]         ptr,
  input logic [(1<<PAGE_W)-1:0]    pvalid
);
  int run_len;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_len <= 0;
    else        run_len <= busy_o ? run_len + 1 : 0;

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_len == WR_CYCLES);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(ptr) && $stable(rdata_o)));

  assert_read_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !busy_o && !load_i && !wr_i && ptr == '1) |=> ptr == '0);

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !busy_o && !load_i) |=>
      ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

  assert_dummy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !busy_o && !load_i && !wr_i && !rd_i && pvalid == '0) |=> !busy_o);
endmodule

bind eeprom_page_ctrl eeprom_page_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .wr_i(wr_i), .rd_i(rd_i),
  .stop_i(stop_i), .rdata_o(rdata_o), .busy_o(busy_o), .ptr(ptr), .pvalid(pvalid)
);

// File: tb/eeprom_page_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_page_ctrl_bench;
  localparam int WR = 20;

  logic clk = 0, rst_n = 0, prot = 0, load = 0, wr = 0, rd = 0, stop = 0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic busy;

  eeprom_page_ctrl #(.WR_CYCLES(WR)) u_eeprom_page_ctrl (
    .clk(clk), .rst_n(rst_n), .prot_i(prot), .load_i(load), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rd_i(rd), .stop_i(stop),
    .rdata_o(rdata), .busy_o(busy)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0]  mdl [512];
  logic [7:0]  mbuf [16];
  logic [15:0] mval;
  logic [8:0]  mptr;
  logic        mprot;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_load(input logic [8:0] a);
    load = 1; addr = a; @(negedge clk); load = 0;
    mptr = a; mval = '0;
  endtask

  task automatic t_write(input logic [7:0] d);
    wr = 1; wdata = d; @(negedge clk); wr = 0;
    mbuf[mptr[3:0]] = d; mval[mptr[3:0]] = 1'b1;
    mptr = {mptr[8:4], 4'(mptr[3:0] + 4'd1)};
  endtask

  task automatic t_read(input string tag);
    rd = 1; @(negedge clk); rd = 0;
    chk(rdata === mdl[mptr], tag, rdata, mdl[mptr]);
    mptr = mptr + 9'd1;
  endtask

  task automatic model_commit();
    for (int j = 0; j < 16; j++) begin
      logic [8:0] a;
      a = {mptr[8:4], 4'(j)};
      if (mval[j] && !(mprot && a[8])) mdl[a] = mbuf[j];
    end
    mval = '0;
  endtask

  task automatic t_stop_commit(input string tag);
    int n;
    bit had;
    had = (mval != 0);
    stop = 1; mprot = prot; @(negedge clk); stop = 0;
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == (had ? WR : 0), tag, n, had ? WR : 0);
    if (had) model_commit();
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(rdata === 8'h00, "R1 rdata", rdata, 0);
    t_read("R1 array zero");
    t_load(9'h155); t_read("R1/R2 load read");
    t_read("R2 read increments");
  endtask

  task automatic t_page_wrap();
    t_load(9'h02E);
    for (int i = 0; i < 18; i++) t_write(8'h80 + 8'(i));
    t_stop_commit("R6 busy length");
    t_read("R10 current address after write");
    t_load(9'h020);
    for (int i = 0; i < 16; i++) t_read("R4/R5 page contents");
    t_read("R5 next page untouched");
  endtask

  task automatic t_dummy();
    t_load(9'h100);
    t_stop_commit("R7 dummy write no busy");
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R7 busy stays low", busy, 0);
    t_read("R7 pointer keeps loaded address");
  endtask

  task automatic t_protect();
    prot = 0;
    t_load(9'h1F0); t_write(8'h11); t_write(8'h22);
    t_stop_commit("R9 unprotected write");
    prot = 1;
    t_load(9'h1F0); t_write(8'hEE); t_write(8'hDD);
    t_stop_commit("R9 protected write still times");
    t_load(9'h0F0); t_write(8'h5A);
    t_stop_commit("R9 lower half cycle");
    prot = 0;
    t_load(9'h1F0); t_read("R9 upper byte kept"); t_read("R9 upper byte kept");
    t_load(9'h0F0); t_read("R9 lower half written");
  endtask

  task automatic t_wrap_read();
    t_load(9'h1FE); t_write(8'hC3); t_write(8'h3C);
    t_stop_commit("R6 top page write");
    t_load(9'h1FE);
    t_read("R3 byte 510"); t_read("R3 byte 511"); t_read("R3 rollover to 0");
  endtask

  task automatic t_busy_ignore();
    t_load(9'h060); t_write(8'h33);
    stop = 1; mprot = prot; @(negedge clk); stop = 0;
    load = 1; addr = 9'h070; @(negedge clk); load = 0;
    wr = 1; wdata = 8'h44; @(negedge clk); wr = 0;
    rd = 1; @(negedge clk); rd = 0;
    stop = 1; @(negedge clk); stop = 0;
    while (busy) @(negedge clk);
    model_commit();
    t_read("R8 pointer unchanged by busy strobes");
    t_load(9'h060); t_read("R8 committed byte");
    t_load(9'h070); t_read("R8 ignored push not stored");
    chk(busy === 1'b0, "R8 ignored stop no new cycle", busy, 0);
  endtask

  task automatic t_conflict();
    logic [7:0] prev;
    t_load(9'h052); t_write(8'h77); t_stop_commit("R6 setup write");
    t_load(9'h050); t_write(8'hAA); t_write(8'hBB);
    stop = 1; mprot = prot; @(negedge clk); stop = 0;
    repeat (WR - 1) @(negedge clk);
    chk(busy === 1'b1, "R6 busy in last cycle", busy, 1);
    prev = rdata;
    rd = 1; @(negedge clk); rd = 0;
    chk(busy === 1'b0, "R6 busy falls after count", busy, 0);
    chk(rdata === prev, "R8 pull in last busy cycle ignored", rdata, prev);
    model_commit();
    t_read("R8 pointer not moved by late pull");
    t_load(9'h050); t_read("R6 committed at fall"); t_read("R6 committed at fall");
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mdl[i] = 8'h00;
    mval = '0; mptr = '0; mprot = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_page_wrap();
    t_dummy();
    t_protect();
    t_wrap_read();
    t_busy_ignore();
    t_conflict();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule